// File: doc/BRIEF.md
# PLL Feedback Ramp Sequencer

This controller retunes a running PLL by moving only its feedback multiplier N to a new value. It uses the PLL's dynamic ramp hardware, so the loop never has to relock. It talks to the PLL through a simple single-cycle register port. In each access cycle the sequencer raises an enable and a select, and read data comes back in the same cycle. Three locations are used:

| Select | Location | Fields the sequencer relies on |
|---|---|---|
| 0 | Coefficient word | M in bits [7:0], N in bits [15:8], post-divider in bits [21:16] |
| 1 | Slowdown control word | Slowdown-via-PLL enable in bit 22, dynamic-ramp enable in bit 31 |
| 2 | Ramp status word | Synchronised ramp-done flag in bit 24 |

A request carries the new N. If the coefficient word already holds that N, the request completes at once. Otherwise the block runs this sequence:

1. Enter slowdown mode.
2. Rewrite the N field after a 1 µs gap.
3. Enable the ramp after a second 1 µs gap.
4. Poll the ramp-done flag for a bounded window.
5. Clean up, then report.

The microsecond timebase is a prescaler inside the block, set by the parameter `TICK_DIV` (clock cycles per µs). The poll window is `POLL_US` microseconds.

Top module: `pll_ndiv_ramp`

## Requirements
- R1: When the N field (bits [15:8]) of the coefficient word equals the requested N, the block makes exactly one coefficient read and no writes. `done` is high on the second cycle after the request cycle, with `timed_out` low.
- R2: Otherwise the block reads the slowdown word. It then writes it back with bit 22 set, bit 31 unchanged and every other bit preserved.
- R3: The block then reads the coefficient word again and writes it back with bits [15:8] replaced by the requested N. All other bits are preserved, and this is the only coefficient write of the run.
- R4: The coefficient write is issued exactly `TICK_DIV`+1 cycles after the coefficient read it modifies, which gives a 1 µs gap.
- R5: Exactly `TICK_DIV`+2 cycles after the coefficient write, the block writes the slowdown word with bits 31 and 22 both set and all other bits preserved. A slowdown write with bit 31 set always has bit 22 set.
- R6: From the cycle after the ramp-enable write, the status word (select 2) is read every cycle. The first read with bit 24 set ends the poll, and the run then reports `timed_out` low.
- R7: If bit 24 is not seen within `POLL_US`×`TICK_DIV` status reads, polling stops after exactly that many reads and `timed_out` is reported high. A flag seen on the last allowed read still counts as success.
- R8: After the poll, with or without a timeout, the block reads the slowdown word and writes it with bits 22 and 31 cleared and the other bits preserved. It reads the slowdown word back on the next cycle, and `done` follows one cycle later.
- R9: `busy` is high from the cycle after the accepted request through the `done` cycle. A request raised while `busy` is high is ignored: it starts no new run and does not change the target N.
- R10: After reset `busy`, `done` and `pll_en` are low. `done` is a single-cycle pulse, and `timed_out` is valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to move N; accepted only when idle |
| start_n | input | 8 | Requested N value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Run ended without seeing ramp-done; valid with `done` |
| pll_en | output | 1 | Register access this cycle |
| pll_we | output | 1 | Access is a write |
| pll_sel | output | 2 | Register select: 0 coefficient, 1 slowdown, 2 status |
| pll_wdata | output | 32 | Write data |
| pll_rdata | input | 32 | Read data, returned in the access cycle |

## Verification
For the no-op path, the bench drives a request at a falling edge and expects `done` at the second falling edge after it. On every other path it checks spacing by timestamping accesses at the register-port edge:

- the coefficient write is `TICK_DIV`+1 cycles after its read;
- the ramp-enable write is `TICK_DIV`+2 cycles after the coefficient write;
- the readback is one cycle after the cleanup write.

The PLL model raises ramp-done a chosen number of cycles after the enable write, so a ramp delay of D cycles must produce exactly D+1 status reads. A timeout must produce exactly `POLL_US`×`TICK_DIV` reads. Outputs are sampled at falling edges only, and the bench confirms that no access occurs in the idle cycles after each `done`.

// File: rtl/pll_ndiv_ramp.sv
module pll_ndiv_ramp #(
  parameter int TICK_DIV = 8,
  parameter int POLL_US  = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  start_n,
  output logic        busy,
  output logic        done,
  output logic        timed_out,
  output logic        pll_en,
  output logic        pll_we,
  output logic [1:0]  pll_sel,
  output logic [31:0] pll_wdata,
  input  logic [31:0] pll_rdata
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int UW = $clog2(POLL_US + 1);
  localparam logic [1:0] SEL_COEFF = 2'd0;
  localparam logic [1:0] SEL_SLOW  = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;
  localparam int B_SLOW = 22;
  localparam int B_RAMP = 31;
  localparam int B_DONE = 24;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(POLL_US - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CHKN, S_SLRD, S_SLWR, S_CFRD, S_GAP1, S_CFWR, S_GAP2,
    S_ENRD, S_ENWR, S_POLL, S_CLRD, S_CLWR, S_RBK, S_FIN
  } st_t;

  st_t           st;
  logic [7:0]    n_tgt;
  logic [31:0]   word;
  logic [PW-1:0] pre;
  logic [UW-1:0] us;
  logic          tmo;

  wire pre_wrap = (pre == PRE_LAST);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign timed_out = tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      n_tgt <= '0;
      word  <= '0;
      pre   <= '0;
      us    <= '0;
      tmo   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          n_tgt <= start_n;
          tmo   <= 1'b0;
          st    <= S_CHKN;
        end
        S_CHKN: st <= (pll_rdata[15:8] == n_tgt) ? S_FIN : S_SLRD;
        S_SLRD: begin word <= pll_rdata; st <= S_SLWR; end
        S_SLWR: st <= S_CFRD;
        S_CFRD: begin word <= pll_rdata; pre <= '0; st <= S_GAP1; end
        S_GAP1: if (pre_wrap) st <= S_CFWR; else pre <= pre + 1'b1;
        S_CFWR: begin pre <= '0; st <= S_GAP2; end
        S_GAP2: if (pre_wrap) st <= S_ENRD; else pre <= pre + 1'b1;
        S_ENRD: begin word <= pll_rdata; st <= S_ENWR; end
        S_ENWR: begin pre <= '0; us <= '0; st <= S_POLL; end
        S_POLL: begin
          if (pll_rdata[B_DONE]) st <= S_CLRD;
          else if (pre_wrap) begin
            pre <= '0;
            if (us == US_LAST) begin
              tmo <= 1'b1;
              st  <= S_CLRD;
            end else us <= us + 1'b1;
          end else pre <= pre + 1'b1;
        end
        S_CLRD: begin word <= pll_rdata; st <= S_CLWR; end
        S_CLWR: st <= S_RBK;
        S_RBK:  st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    pll_en    = 1'b0;
    pll_we    = 1'b0;
    pll_sel   = SEL_COEFF;
    pll_wdata = word;
    case (st)
      S_CHKN, S_CFRD: pll_en = 1'b1;
      S_SLRD, S_ENRD, S_CLRD, S_RBK: begin pll_en = 1'b1; pll_sel = SEL_SLOW; end
      S_POLL: begin pll_en = 1'b1; pll_sel = SEL_STAT; end
      S_SLWR: begin
        pll_en = 1'b1; pll_we = 1'b1; pll_sel = SEL_SLOW;
        pll_wdata[B_SLOW] = 1'b1;
      end
      S_CFWR: begin
        pll_en = 1'b1; pll_we = 1'b1;
        pll_wdata[15:8] = n_tgt;
      end
      S_ENWR: begin
        pll_en = 1'b1; pll_we = 1'b1; pll_sel = SEL_SLOW;
        pll_wdata[B_RAMP] = 1'b1;
      end
      S_CLWR: begin
        pll_en = 1'b1; pll_we = 1'b1; pll_sel = SEL_SLOW;
        pll_wdata[B_RAMP] = 1'b0;
        pll_wdata[B_SLOW] = 1'b0;
      end
      default: ;
    endcase
  end

  AST_NOOP_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHKN && pll_rdata[15:8] == n_tgt) |=> (done && !timed_out)); // R1
  AST_RAMP_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en && pll_we && pll_sel == SEL_SLOW && pll_wdata[B_RAMP]) |-> pll_wdata[B_SLOW]); // R5
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (us <= US_LAST)); // R7
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pll_en && !pll_we)); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_tgt)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: tb/pll_ndiv_ramp_test.sv
module pll_ndiv_ramp_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV = 8;
  localparam int POLL_US  = 500;
  localparam int LIMIT    = TICK_DIV * POLL_US;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] start_n = '0;
  logic busy, done, timed_out, pll_en, pll_we;
  logic [1:0] pll_sel;
  logic [31:0] pll_wdata, pll_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ndiv_ramp #(.TICK_DIV(TICK_DIV), .POLL_US(POLL_US)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_n(start_n),
    .busy(busy), .done(done), .timed_out(timed_out),
    .pll_en(pll_en), .pll_we(pll_we), .pll_sel(pll_sel),
    .pll_wdata(pll_wdata), .pll_rdata(pll_rdata));

  // PLL register model
  logic [31:0] m_coeff, m_slow;
  integer rcnt, rdel;
  integer cyc = 0;
  integer n_crd, n_cwr, n_srd, n_swr, n_stat, t_crd, t_cwr, t_rbk;
  integer t_swr [3];
  logic [31:0] d_swr [3];
  wire stat_done = m_slow[31] && (rcnt == 0);

  always_comb begin
    case (pll_sel)
      2'd0: pll_rdata = m_coeff;
      2'd1: pll_rdata = m_slow;
      2'd2: pll_rdata = {7'd0, stat_done, 24'd0};
      default: pll_rdata = 32'hDEAD_BEEF;
    endcase
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rcnt > 0) rcnt = rcnt - 1;
    if (pll_en) begin
      if (pll_we) begin
        if (pll_sel == 2'd0) begin m_coeff = pll_wdata; n_cwr++; t_cwr = cyc; end
        else if (pll_sel == 2'd1) begin
          if (n_swr < 3) begin t_swr[n_swr] = cyc; d_swr[n_swr] = pll_wdata; end
          n_swr++;
          if (pll_wdata[31] && !m_slow[31]) rcnt = rdel;
          if (!pll_wdata[31]) rcnt = -1;
          m_slow = pll_wdata;
        end
      end else begin
        if (pll_sel == 2'd0) begin n_crd++; t_crd = cyc; end
        else if (pll_sel == 2'd1) begin n_srd++; t_rbk = cyc; end
        else n_stat++;
      end
    end
  end

  integer checks = 0, errors = 0;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_coeff(input logic [31:0] c, input logic [7:0] n);
    return {c[31:16], n, c[7:0]};
  endfunction

  task automatic run_case(input logic [31:0] c0, input logic [7:0] nn,
                          input integer d, input bit poke);
    logic [31:0] s0;
    integer k, acc_before;
    bit got, busy_bad, noop, exp_tmo;
    s0 = $urandom() & ~32'h8040_0000;
    @(negedge clk);
    m_coeff = c0; m_slow = s0; rdel = d; rcnt = -1;
    n_crd = 0; n_cwr = 0; n_srd = 0; n_swr = 0; n_stat = 0;
    t_crd = 0; t_cwr = 0; t_rbk = 0;
    start = 1'b1; start_n = nn;
    k = 0; got = 0; busy_bad = 0;
    while (!got && k < LIMIT + 200) begin
      @(negedge clk);
      k++;
      start = poke && (k == 1);
      if (poke && k == 1) start_n = nn ^ 8'hA5;
      if (done) got = 1;
      else if (!busy) busy_bad = 1;
    end
    start = 1'b0;
    check(got, "R9 watchdog done", got, 1);
    check(!busy_bad && busy, "R9 busy through run", busy_bad, 0);
    noop = (c0[15:8] == nn);
    exp_tmo = !noop && (d < 0 || d + 1 > LIMIT);
    check(timed_out == exp_tmo, "R6/R7 status", timed_out, exp_tmo);
    if (noop) begin
      check(k == 2, "R1 latency", k, 2);
      check(n_crd == 1 && n_cwr == 0 && n_swr == 0 && n_srd == 0, "R1 accesses",
            n_crd * 16 + n_cwr + n_swr, 16);
    end else begin
      check(n_swr == 3 && n_srd == 4, "R8 slowdown access count", n_swr * 16 + n_srd, 16'h34);
      check(d_swr[0] == (s0 | 32'h0040_0000), "R2 slowdown set", d_swr[0], s0 | 32'h0040_0000);
      check(n_cwr == 1 && m_coeff == exp_coeff(c0, nn), "R3 coefficient", m_coeff, exp_coeff(c0, nn));
      check(t_cwr - t_crd == TICK_DIV + 1, "R4 gap", t_cwr - t_crd, TICK_DIV + 1);
      check(t_swr[1] - t_cwr == TICK_DIV + 2, "R5 gap", t_swr[1] - t_cwr, TICK_DIV + 2);
      check(d_swr[1] == (s0 | 32'h8040_0000), "R5 ramp enable", d_swr[1], s0 | 32'h8040_0000);
      check(n_stat == (exp_tmo ? LIMIT : d + 1), "R6/R7 poll reads", n_stat, exp_tmo ? LIMIT : d + 1);
      check(d_swr[2] == s0 && m_slow == s0, "R8 cleanup", d_swr[2], s0);
      check(t_rbk == t_swr[2] + 1, "R8 readback", t_rbk - t_swr[2], 1);
    end
    acc_before = n_crd + n_cwr + n_srd + n_swr + n_stat;
    repeat (4) @(negedge clk);
    check(!busy && !done && (n_crd + n_cwr + n_srd + n_swr + n_stat) == acc_before,
          "R9/R10 idle after done", n_crd + n_cwr + n_srd + n_swr + n_stat, acc_before);
  endtask

  initial begin
    logic [31:0] c;
    void'($urandom(32'd4242));
    rcnt = -1; rdel = -1; m_coeff = '0; m_slow = '0;
    n_crd = 0; n_cwr = 0; n_srd = 0; n_swr = 0; n_stat = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !pll_en, "R10 reset state", {busy, done, pll_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !pll_en, "R10 idle", {busy, done, pll_en}, 0);
    c = 32'h0015_3A01;
    run_case(c, 8'h3A, 5, 1'b0);          // R1 no-op
    run_case(c, 8'h50, 0, 1'b0);          // R6 immediate flag
    run_case(c, 8'h51, 37, 1'b1);         // R9 request while busy
    run_case(c, 8'h52, LIMIT - 1, 1'b0);  // R7 flag on last read
    run_case(c, 8'h53, LIMIT, 1'b0);      // R7 timeout
    run_case(c, 8'h54, -1, 1'b0);         // R8 cleanup after timeout
    for (int i = 0; i < 12; i++) begin
      logic [31:0] rc;
      logic [7:0] rn;
      rc = $urandom();
      rn = ($urandom() % 4 == 0) ? rc[15:8] : 8'($urandom());
      run_case(rc, rn, int'($urandom() % 80), ($urandom() % 2) == 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule